// File: doc/BRIEF.md
# Range-Matching Fully Associative Translation Buffer

This block caches address translations in a small set of fully associative entries. Each entry describes one mapped region: a virtual start address, a region length in bytes, and a physical base. A lookup hits an entry when the virtual address falls inside the half-open interval from the start address to the start plus the length. Because a hit is decided by range and not by equal page numbers, regions of different lengths can sit side by side in the same structure. The physical address is the entry's physical base with the low 12 bits of the virtual address OR-ed in.

Lookups are combinational. A lookup can also ask that the entry it hit be moved to the most recently used position. Inserts complete in one clock. An insert fills an empty entry when one exists and otherwise replaces the least recently used entry. The block keeps a strict recency rank for every valid entry and resolves overlapping matches in favour of the most recent one. A flush input empties the whole structure in one cycle. Inserts are not compared against the entries already present, so overlapping regions may be installed.

Top module: `tlb_range_top`

## Requirements
- R1: After reset no entry is valid, so every lookup misses (`lk_hit` = 0).
- R2: A lookup hits a valid entry when start <= va and va < start + length, with the sum computed one bit wider so that it cannot wrap. An entry of length 0 never hits.
- R3: On a hit, `lk_pa` = entry physical base OR {zeros, va[11:0]}.
- R4: While fewer than N entries are valid, an insert uses an empty entry and every entry already present stays resident.
- R5: When all N entries are valid, an insert replaces the least recently used entry, and only that entry is lost.
- R6: An inserted entry becomes the most recently used and hits from the next cycle on.
- R7: A hit with `lk_promote` = 1 moves the hit entry to most recently used at the next edge. A lookup with `lk_promote` = 0, or a lookup that misses, leaves the recency order unchanged.
- R8: When several valid entries match one address, the most recently used of them supplies `lk_pa`.
- R9: `flush_all` = 1 invalidates every entry at the next edge and takes priority over an insert in the same cycle, which is dropped.
- R10: If an insert and a promoting lookup occur in the same cycle, the insert is performed and the promotion is dropped. The lookup result in that cycle reflects the contents before the insert.
- R11: An insert is accepted even when its region overlaps resident entries, and `lk_hit` is 0 whenever `lk_vld` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vld | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_promote | input | 1 | Move the hit entry to most recently used |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_pa | output | PA_W | Translated physical address (combinational) |
| ins_vld | input | 1 | Insert request |
| ins_start | input | VA_W | Virtual start of the new region |
| ins_len | input | LEN_W | Length of the new region in bytes |
| ins_pbase | input | PA_W | Physical base of the new region |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench targets eviction order after mixed promoting and non-promoting hits. A design that promoted on every hit, or never promoted, would evict the wrong entry, and a later lookup would miss where the model expects a hit. Overlapping regions check the pick among several matches: choosing by index instead of by recency returns another entry's physical base. Range edges (the last byte inside, the first byte past the end, zero-length regions, and a physical base with low bits set) expose off-by-one comparators, wrapping sums and a replace-instead-of-OR address merge. The bench also drives an insert in the same cycle as a flush and in the same cycle as a promoting lookup. A design that ordered these wrongly would keep an entry after the flush, or would keep the wrong entry on the next eviction.

// File: rtl/tlb_range_pkg.sv
package tlb_range_pkg;
  localparam int PG_OFS_W = 12;

  typedef enum logic [1:0] {
    UPD_IDLE    = 2'd0,
    UPD_FLUSH   = 2'd1,
    UPD_INSERT  = 2'd2,
    UPD_PROMOTE = 2'd3
  } upd_e;
endpackage

// File: rtl/tlb_range_match.sv
module tlb_range_match #(
  parameter int VA_W  = 32,
  parameter int LEN_W = 32
) (
  input  logic             valid_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [VA_W-1:0]  start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             match_o
);
  localparam int SUM_W = ((VA_W > LEN_W) ? VA_W : LEN_W) + 1;

  logic [SUM_W-1:0] lo_ext, va_ext, end_ext;

  always_comb begin
    lo_ext  = SUM_W'(start_i);
    va_ext  = SUM_W'(va_i);
    end_ext = lo_ext + SUM_W'(len_i);
    match_o = valid_i && (lo_ext <= va_ext) && (va_ext < end_ext);
  end
endmodule

// File: rtl/tlb_range_pick.sv
module tlb_range_pick #(
  parameter int N     = 8,
  parameter int AGE_W = 3
) (
  input  logic [N-1:0]       match_i,
  input  logic [N*AGE_W-1:0] age_i,
  output logic               hit_o,
  output logic [AGE_W-1:0]   idx_o
);
  logic [AGE_W:0] best;

  always_comb begin
    best  = (AGE_W+1)'(N);
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && ({1'b0, age_i[i*AGE_W +: AGE_W]} < best)) begin
        best  = {1'b0, age_i[i*AGE_W +: AGE_W]};
        idx_o = AGE_W'(i);
      end
    end
    hit_o = |match_i;
  end
endmodule

// File: rtl/tlb_range_age.sv
module tlb_range_age
  import tlb_range_pkg::*;
#(
  parameter int N     = 8,
  parameter int AGE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               ins_i,
  input  logic               prom_i,
  input  logic [AGE_W-1:0]   prom_idx_i,
  output logic [N-1:0]       valid_o,
  output logic [N*AGE_W-1:0] age_o,
  output logic [AGE_W-1:0]   slot_o
);
  logic [N-1:0]     valid_q, valid_d;
  logic [AGE_W-1:0] age_q [N];
  logic [AGE_W-1:0] age_d [N];
  logic             full;
  logic [AGE_W-1:0] free_idx, victim_idx, tgt;
  logic [AGE_W:0]   thr;
  upd_e             upd;

  always_comb begin
    full       = &valid_q;
    free_idx   = '0;
    victim_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = AGE_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == AGE_W'(N-1)) victim_idx = AGE_W'(i);
    end
    slot_o = full ? victim_idx : free_idx;

    if (flush_i)     upd = UPD_FLUSH;
    else if (ins_i)  upd = UPD_INSERT;
    else if (prom_i) upd = UPD_PROMOTE;
    else             upd = UPD_IDLE;

    tgt = (upd == UPD_INSERT) ? slot_o : prom_idx_i;
    if (upd == UPD_INSERT) thr = full ? (AGE_W+1)'(N-1) : (AGE_W+1)'(N);
    else                   thr = {1'b0, age_q[prom_idx_i]};

    valid_d = valid_q;
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (upd == UPD_FLUSH) begin
        valid_d[i] = 1'b0;
      end else if (upd != UPD_IDLE) begin
        if (AGE_W'(i) == tgt) begin
          valid_d[i] = 1'b1;
          age_d[i]   = '0;
        end else if (valid_q[i] && ({1'b0, age_q[i]} < thr)) begin
          age_d[i] = age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < N; i++) age_q[i] <= '0;
    end else if (upd != UPD_IDLE) begin
      valid_q <= valid_d;
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  assign valid_o = valid_q;
  for (genvar g = 0; g < N; g++) begin : g_age_out
    assign age_o[g*AGE_W +: AGE_W] = age_q[g];
  end
endmodule

// File: rtl/tlb_range_top.sv
module tlb_range_top
  import tlb_range_pkg::*;
#(
  parameter int N     = 8,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_vld,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_promote,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_pa,
  input  logic             ins_vld,
  input  logic [VA_W-1:0]  ins_start,
  input  logic [LEN_W-1:0] ins_len,
  input  logic [PA_W-1:0]  ins_pbase,
  input  logic             flush_all
);
  localparam int AGE_W = (N > 1) ? $clog2(N) : 1;

  logic [VA_W-1:0]  start_q [N];
  logic [LEN_W-1:0] len_q   [N];
  logic [PA_W-1:0]  pbase_q [N];

  logic [N-1:0]       ent_valid;
  logic [N*AGE_W-1:0] age_flat;
  logic [N-1:0]       match;
  logic               any_match;
  logic [AGE_W-1:0]   hit_idx, slot;
  logic               ins_go, prom_go;

  for (genvar g = 0; g < N; g++) begin : g_ent
    tlb_range_match #(.VA_W(VA_W), .LEN_W(LEN_W)) match_i (
      .valid_i (ent_valid[g]),
      .va_i    (lk_va),
      .start_i (start_q[g]),
      .len_i   (len_q[g]),
      .match_o (match[g])
    );

    always_ff @(posedge clk) begin
      if (ins_go && (slot == AGE_W'(g))) begin
        start_q[g] <= ins_start;
        len_q[g]   <= ins_len;
        pbase_q[g] <= ins_pbase;
      end
    end
  end

  tlb_range_pick #(.N(N), .AGE_W(AGE_W)) pick_i (
    .match_i (match),
    .age_i   (age_flat),
    .hit_o   (any_match),
    .idx_o   (hit_idx)
  );

  always_comb begin
    ins_go  = ins_vld && !flush_all;
    prom_go = lk_vld && lk_promote && any_match && !ins_vld && !flush_all;
    lk_hit  = lk_vld && any_match;
    lk_pa   = pbase_q[hit_idx] | PA_W'(lk_va[PG_OFS_W-1:0]);
  end

  tlb_range_age #(.N(N), .AGE_W(AGE_W)) age_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_all),
    .ins_i      (ins_go),
    .prom_i     (prom_go),
    .prom_idx_i (hit_idx),
    .valid_o    (ent_valid),
    .age_o      (age_flat),
    .slot_o     (slot)
  );
endmodule

// File: rtl/tlb_range_chk.sv
module tlb_range_chk #(
  parameter int N     = 8,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int LEN_W = 32,
  parameter int AGE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_vld,
  input logic [VA_W-1:0]    lk_va,
  input logic               lk_promote,
  input logic               lk_hit,
  input logic [PA_W-1:0]    lk_pa,
  input logic               ins_vld,
  input logic [VA_W-1:0]    ins_start,
  input logic [LEN_W-1:0]   ins_len,
  input logic               flush_all,
  input logic [N-1:0]       ent_valid,
  input logic [N*AGE_W-1:0] age_flat
);
  AST_PA_LOW_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_pa[11:0] & lk_va[11:0]) == lk_va[11:0])); // R3

  AST_FREE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && !flush_all && ($countones(ent_valid) < N))
      |=> ($countones(ent_valid) == $past($countones(ent_valid)) + 1)); // R4

  AST_NEW_ENTRY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ins_vld && !flush_all && (ins_len != '0))
      && lk_vld && (lk_va == $past(ins_start))) |-> lk_hit); // R6

  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_all && !ins_vld && !(lk_vld && lk_promote))
      |=> ($stable(age_flat) && $stable(ent_valid))); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (ent_valid == '0)); // R9

  AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |-> !lk_hit); // R11
endmodule

bind tlb_range_top tlb_range_chk #(
  .N(N), .VA_W(VA_W), .PA_W(PA_W), .LEN_W(LEN_W), .AGE_W(AGE_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_vld     (lk_vld),
  .lk_va      (lk_va),
  .lk_promote (lk_promote),
  .lk_hit     (lk_hit),
  .lk_pa      (lk_pa),
  .ins_vld    (ins_vld),
  .ins_start  (ins_start),
  .ins_len    (ins_len),
  .flush_all  (flush_all),
  .ent_valid  (ent_valid),
  .age_flat   (age_flat)
);

// File: tb/tlb_range_tb_top.sv
module tlb_range_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_vld, lk_promote, lk_hit, ins_vld, flush_all;
  logic [31:0] lk_va, lk_pa, ins_start, ins_len, ins_pbase;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_start [N];
  logic [31:0] m_len   [N];
  logic [31:0] m_pb    [N];
  int          m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_range_top #(.N(N), .VA_W(32), .PA_W(32), .LEN_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_va(lk_va),
    .lk_promote(lk_promote), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .ins_vld(ins_vld), .ins_start(ins_start), .ins_len(ins_len),
    .ins_pbase(ins_pbase), .flush_all(flush_all)
  );

  function automatic int m_find(logic [31:0] va);
    for (int k = 0; k < m_cnt; k++) begin
      if (({1'b0, m_start[k]} <= {1'b0, va}) &&
          (({1'b0, m_start[k]} + {1'b0, m_len[k]}) > {1'b0, va}))
        return k;
    end
    return -1;
  endfunction

  task automatic m_front(int k);
    logic [31:0] s, l, p;
    s = m_start[k]; l = m_len[k]; p = m_pb[k];
    for (int j = k; j > 0; j--) begin
      m_start[j] = m_start[j-1]; m_len[j] = m_len[j-1]; m_pb[j] = m_pb[j-1];
    end
    m_start[0] = s; m_len[0] = l; m_pb[0] = p;
  endtask

  task automatic m_insert(logic [31:0] s, logic [31:0] l, logic [31:0] p);
    if (m_cnt < N) m_cnt++;
    for (int j = m_cnt - 1; j > 0; j--) begin
      m_start[j] = m_start[j-1]; m_len[j] = m_len[j-1]; m_pb[j] = m_pb[j-1];
    end
    m_start[0] = s; m_len[0] = l; m_pb[0] = p;
  endtask

  task automatic step(bit lk, logic [31:0] va, bit pr, bit ins,
                      logic [31:0] s, logic [31:0] l, logic [31:0] p,
                      bit fl, string tag);
    int k;
    logic exp_hit;
    logic [31:0] exp_pa;
    @(negedge clk);
    lk_vld = lk; lk_va = va; lk_promote = pr;
    ins_vld = ins; ins_start = s; ins_len = l; ins_pbase = p;
    flush_all = fl;
    #1;
    k = m_find(va);
    if (lk) begin
      exp_hit = (k >= 0);
      exp_pa  = exp_hit ? (m_pb[k] | {20'h0, va[11:0]}) : 32'h0;
      checks++;
      if (lk_hit !== exp_hit) begin
        errors++;
        $display("FAIL %s hit va=%h actual=%b expected=%b", tag, va, lk_hit, exp_hit);
      end
      if (exp_hit) begin
        checks++;
        if (lk_pa !== exp_pa) begin
          errors++;
          $display("FAIL %s pa va=%h actual=%h expected=%h", tag, va, lk_pa, exp_pa);
        end
      end
    end else begin
      checks++;
      if (lk_hit !== 1'b0) begin
        errors++;
        $display("FAIL R11 hit without request actual=%b expected=0", lk_hit);
      end
    end
    @(posedge clk);
    if (fl)                   m_cnt = 0;
    else if (ins)             m_insert(s, l, p);
    else if (lk && pr && k >= 0) m_front(k);
  endtask

  task automatic probe(logic [31:0] va, bit pr, string tag);
    step(1'b1, va, pr, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, tag);
  endtask

  task automatic put(logic [31:0] s, logic [31:0] l, logic [31:0] p);
    step(1'b0, 32'h0, 1'b0, 1'b1, s, l, p, 1'b0, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_tmp;
    seed_tmp = $urandom(32'h5EED_1234);
    rst_n = 1'b0; lk_vld = 0; lk_va = 0; lk_promote = 0;
    ins_vld = 0; ins_start = 0; ins_len = 0; ins_pbase = 0; flush_all = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    probe(32'h0000_0000, 1'b1, "R1");
    probe(32'h0001_0000, 1'b0, "R1");

    // R2, R3: range edges
    put(32'h0001_0000, 32'h1000, 32'hA000_0000);
    probe(32'h0001_0FFF, 1'b0, "R2");
    probe(32'h0001_1000, 1'b0, "R2");
    probe(32'h0000_FFFF, 1'b0, "R2");
    probe(32'h0001_0000, 1'b0, "R6");
    put(32'h0004_0000, 32'h1_0000, 32'hB000_0000);
    probe(32'h0004_F123, 1'b0, "R2");
    put(32'h0008_0000, 32'h0, 32'hD000_0000);
    probe(32'h0008_0000, 1'b0, "R2");
    put(32'hFFFF_F000, 32'h2000, 32'hE000_0000);
    probe(32'hFFFF_FFFF, 1'b0, "R2");
    put(32'h000C_0000, 32'h1000, 32'hC000_0F0F);
    probe(32'h000C_00F0, 1'b0, "R3");

    // R8, R11: overlapping insert wins while most recent
    put(32'h0001_0000, 32'h2000, 32'h9000_0000);
    probe(32'h0001_0800, 1'b0, "R8");
    probe(32'h0001_1800, 1'b0, "R11");

    // R9: flush, and flush beating an insert
    step(1'b0, 0, 0, 1'b0, 0, 0, 0, 1'b1, "R9");
    probe(32'h0001_0800, 1'b0, "R9");
    step(1'b0, 0, 0, 1'b1, 32'h0002_0000, 32'h1000, 32'h1000_0000, 1'b1, "R9");
    probe(32'h0002_0000, 1'b0, "R9");

    // R4, R5, R7: fill, promote, evict
    for (int e = 0; e < N; e++)
      put(32'h0010_0000 + e * 32'h1000, 32'h1000, (e + 1) << 20);
    for (int e = 0; e < N; e++)
      probe(32'h0010_0000 + e * 32'h1000 + 32'h10, 1'b0, "R4");
    probe(32'h0010_0000, 1'b1, "R7");
    put(32'h0020_0000, 32'h1000, 32'h0F00_0000);
    probe(32'h0010_1000, 1'b0, "R5");
    probe(32'h0010_0000, 1'b0, "R7");
    probe(32'h0010_2000, 1'b0, "R7");
    put(32'h0021_0000, 32'h1000, 32'h0E00_0000);
    probe(32'h0010_2000, 1'b0, "R5");

    // R10: insert with a promoting lookup in one cycle
    step(1'b1, 32'h0010_4000, 1'b1, 1'b1, 32'h0022_0000, 32'h1000, 32'h0D00_0000, 1'b0, "R10");
    put(32'h0023_0000, 32'h1000, 32'h0C00_0000);
    probe(32'h0010_4000, 1'b0, "R10");
    probe(32'h0022_0000, 1'b0, "R6");

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      int r;
      logic [31:0] s, l, p, va;
      r  = $urandom_range(0, 99);
      va = $urandom_range(0, 32'h2_7FFF);
      s  = $urandom_range(0, 39) << 12;
      case ($urandom_range(0, 4))
        0: l = 32'h0;
        1: l = 32'h1000;
        2: l = 32'h2000;
        3: l = 32'h8000;
        default: l = 32'h1_0000;
      endcase
      p = $urandom & 32'hFFFF_F000;
      if (r < 3)       step(1'b0, 0, 0, 1'b0, 0, 0, 0, 1'b1, "R9");
      else if (r < 13) step(1'b1, va, 1'b1, 1'b1, s, l, p, 1'b0, "R10");
      else if (r < 40) put(s, l, p);
      else             probe(va, r[0], "R8");
    end

    @(negedge clk);
    lk_vld = 0; ins_vld = 0; flush_all = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule